// File: doc/BRIEF.md
# Victim Line Buffer

This block is a small, fully associative store of whole cache lines that sits next to a direct-mapped first-level cache. Lines pushed out of the first-level cache arrive on an insert port together with their block number. The buffer keeps them so that a later reference can still find them.

Every lookup that the first-level cache makes is also presented here. All entries are compared against the block number in parallel, and the hit flag and the line come back combinationally. The reply therefore lands in the same cycle as a first-level hit would.

On a hit the line returns to the first-level cache, which usually has to give up a line of its own to make room. That displaced line is handed over on the swap port in the same cycle. It takes over the entry that just hit, so a swap never pushes anything else out. A lookup that hits with no swap simply frees the entry. When an insert finds every entry occupied, the least recently used entry is dropped. Recency is kept with one age counter per entry.

Top module: `victim_cache`

## Requirements
- R1: After reset every entry is invalid, so no lookup hits until a line has been written.
- R2: A lookup with `lkp_valid` high raises `lkp_hit` in the same cycle, combinationally, when any valid entry holds `lkp_tag`. On a hit, `lkp_line` carries that entry's line. It is zero on a miss.
- R3: An insert taken while an entry is free stores the line in the lowest-numbered free entry and discards nothing.
- R4: An insert taken while all entries are valid replaces the least recently used entry, and only that entry.
- R5: An entry becomes most recently used when it is written by an insert or by a swap. The other entries keep their relative order.
- R6: When a lookup hits and `swap_valid` is high in the same cycle, the hit entry is overwritten with `swap_tag`/`swap_line`. The hit line leaves the buffer and no other entry changes.
- R7: When a lookup hits and `swap_valid` is low, the hit entry becomes invalid.
- R8: An insert is ignored in any cycle in which the lookup hits.
- R9: The swap port is ignored in any cycle in which the lookup misses or `lkp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Line evicted from the first-level cache is offered |
| ins_tag | input | TAG_W | Block number of the inserted line |
| ins_line | input | LINE_W | Inserted line data |
| lkp_valid | input | 1 | Lookup request |
| lkp_tag | input | TAG_W | Block number being looked up |
| lkp_hit | output | 1 | Lookup found a valid entry (same cycle) |
| lkp_line | output | LINE_W | Line of the hit entry, zero on a miss |
| swap_valid | input | 1 | Line displaced by the returning line is offered |
| swap_tag | input | TAG_W | Block number of the displaced line |
| swap_line | input | LINE_W | Displaced line data |

## Verification
The bound checker watches several properties on every cycle. It checks that a lookup never matches two entries, that exactly one entry is the eviction candidate, and how the count of valid entries moves. Inserting into free space adds one entry, inserting into a full buffer keeps it full, a swap keeps the count, and a hit without a swap removes one. Which line is actually dropped, and whether ignored inserts and swaps leave no trace, can only be shown by the bench. It runs long lookup/insert/swap sequences against an independent timestamp-ordered model and reads back each block number through later lookups.

// File: rtl/victim_cache.sv
module victim_cache #(
  parameter int N      = 4,
  parameter int TAG_W  = 27,
  parameter int LINE_W = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  input  logic [TAG_W-1:0]  ins_tag,
  input  logic [LINE_W-1:0] ins_line,
  input  logic              lkp_valid,
  input  logic [TAG_W-1:0]  lkp_tag,
  output logic              lkp_hit,
  output logic [LINE_W-1:0] lkp_line,
  input  logic              swap_valid,
  input  logic [TAG_W-1:0]  swap_tag,
  input  logic [LINE_W-1:0] swap_line
);
  localparam int AW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]             valid_q;
  logic [N-1:0]             match;
  logic [N-1:0][TAG_W-1:0]  tag_q;
  logic [N-1:0][LINE_W-1:0] line_q;
  logic [N-1:0][AW-1:0]     age_q;
  logic [AW-1:0]            hidx, slot, tidx;
  logic                     do_swap, do_free, do_ins, touch;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign match[i] = lkp_valid && valid_q[i] && (tag_q[i] == lkp_tag);
  end

  assign lkp_hit = |match;
  assign do_swap = lkp_hit && swap_valid;
  assign do_free = lkp_hit && !swap_valid;
  assign do_ins  = ins_valid && !lkp_hit;
  assign touch   = do_swap || do_ins;
  assign tidx    = do_swap ? hidx : slot;

  always_comb begin
    lkp_line = '0;
    hidx     = '0;
    for (int i = 0; i < N; i++)
      if (match[i]) begin
        lkp_line = lkp_line | line_q[i];
        hidx     = AW'(i);
      end
  end

  always_comb begin
    slot = '0;
    for (int i = 0; i < N; i++)
      if (age_q[i] == '0) slot = AW'(i);
    for (int i = N - 1; i >= 0; i--)
      if (!valid_q[i]) slot = AW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      for (int i = 0; i < N; i++) age_q[i] <= AW'(i);
    end else begin
      if (do_free) valid_q[hidx] <= 1'b0;
      if (touch) begin
        valid_q[tidx] <= 1'b1;
        for (int j = 0; j < N; j++)
          if (AW'(j) == tidx) age_q[j] <= AW'(N - 1);
          else if (age_q[j] > age_q[tidx]) age_q[j] <= age_q[j] - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (touch) begin
      tag_q[tidx]  <= do_swap ? swap_tag  : ins_tag;
      line_q[tidx] <= do_swap ? swap_line : ins_line;
    end
  end
endmodule

module victim_cache_chk #(
  parameter int N  = 4,
  parameter int AW = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ins_valid,
  input logic                 swap_valid,
  input logic                 lkp_hit,
  input logic [N-1:0]         match,
  input logic [N-1:0]         valid_q,
  input logic [N-1:0][AW-1:0] age_q
);
  logic [N-1:0] oldest;
  for (genvar i = 0; i < N; i++) begin : g_old
    assign oldest[i] = (age_q[i] == '0);
  end

  AST_EMPTY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (valid_q == '0)); // R1
  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match)); // R2
  AST_ONE_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldest) == 1); // R5
  AST_FREE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !lkp_hit && $countones(valid_q) < N) |=>
      $countones(valid_q) == $past($countones(valid_q)) + 1); // R3
  AST_FULL_STAYS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !lkp_hit && $countones(valid_q) == N) |=>
      $countones(valid_q) == N); // R4
  AST_SWAP_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (lkp_hit && swap_valid) |=> $countones(valid_q) == $past($countones(valid_q))); // R6
  AST_HIT_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (lkp_hit && !swap_valid) |=> $countones(valid_q) == $past($countones(valid_q)) - 1); // R7
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ins_valid && !lkp_hit) |=> $stable(valid_q)); // R9
endmodule

bind victim_cache victim_cache_chk #(.N(N), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .swap_valid(swap_valid),
  .lkp_hit(lkp_hit), .match(match), .valid_q(valid_q), .age_q(age_q)
);

// File: tb/victim_cache_test.sv
module victim_cache_test;
  localparam int N = 4, TAG_W = 27, LINE_W = 256, POOL = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ins_valid = 1'b0, lkp_valid = 1'b0, swap_valid = 1'b0, lkp_hit;
  logic [TAG_W-1:0] ins_tag = '0, lkp_tag = '0, swap_tag = '0;
  logic [LINE_W-1:0] ins_line = '0, swap_line = '0, lkp_line;

  always #5 clk = ~clk;

  victim_cache #(.N(N), .TAG_W(TAG_W), .LINE_W(LINE_W)) uut (.*);

  int errors = 0, checks = 0, stamp = 0;
  logic [31:0] gen = 32'h1000;
  logic [15:0] lfsr = 16'hACE1;
  bit m_v[N];
  int m_tag[N], m_st[N];
  logic [LINE_W-1:0] m_line[N];
  string fate[POOL];

  task automatic check(bit ok, string req, string what, logic [LINE_W-1:0] act, logic [LINE_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int find(int t);
    for (int i = 0; i < N; i++) if (m_v[i] && m_tag[i] == t) return i;
    return -1;
  endfunction

  function automatic int fresh(int start, int avoid);
    for (int k = 0; k < POOL; k++) begin
      int t = (start + k) % POOL;
      if (find(t) < 0 && t != avoid) return t;
    end
    return 0;
  endfunction

  function automatic int pick_slot();
    int s = 0;
    for (int i = N - 1; i >= 0; i--) if (!m_v[i]) s = i;
    if (m_v[s]) for (int i = 0; i < N; i++) if (m_st[i] < m_st[s]) s = i;
    return s;
  endfunction

  task automatic step();
    int t, h, st, it;
    bit lv, sv, iv;
    @(negedge clk);
    lfsr = {lfsr[14:0], 1'b0} ^ (lfsr[15] ? 16'h002D : 16'h0000);
    lv = lfsr[0] | lfsr[1];
    t  = int'(lfsr[5:2]) % POOL;
    h  = lv ? find(t) : -1;
    sv = lfsr[6] | lfsr[7];
    iv = lfsr[8] | lfsr[9];
    st = fresh(int'(lfsr[13:10]), t);
    it = fresh(st + 1, t);
    lkp_valid = lv; lkp_tag = TAG_W'(t);
    swap_valid = sv; swap_tag = TAG_W'(st); swap_line = {8{gen}};
    ins_valid = iv; ins_tag = TAG_W'(it); ins_line = {8{gen + 32'd1}};
    #1;
    if (lv) begin
      check(lkp_hit == (h >= 0), {"R2 ", fate[t]}, "hit", LINE_W'(lkp_hit), LINE_W'(h >= 0));
      check(lkp_line == (h >= 0 ? m_line[h] : '0), {"R2 ", fate[t]}, "line",
            lkp_line, h >= 0 ? m_line[h] : '0);
    end
    if (h >= 0) begin
      fate[t] = sv ? "R6" : "R7";
      if (iv) fate[it] = "R8";
      if (sv) begin
        m_tag[h] = st; m_line[h] = swap_line; m_st[h] = ++stamp; fate[st] = "R6 R5";
      end else m_v[h] = 0;
    end else begin
      if (sv && st != it) fate[st] = "R9";
      if (iv) begin
        int s = pick_slot();
        if (m_v[s]) fate[m_tag[s]] = "R4 R5";
        m_v[s] = 1; m_tag[s] = it; m_line[s] = ins_line; m_st[s] = ++stamp; fate[it] = "R3";
      end
    end
    gen = gen + 32'd2;
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin m_v[i] = 0; m_st[i] = 0; m_tag[i] = 0; m_line[i] = '0; end
    for (int i = 0; i < POOL; i++) fate[i] = "R1";
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    for (int t = 0; t < 16; t++) begin
      @(negedge clk);
      lkp_valid = 1'b1; lkp_tag = TAG_W'(t);
      #1 check(!lkp_hit && lkp_line == '0, "R1", "hit after reset", LINE_W'(lkp_hit), '0);
    end
    for (int n = 0; n < 4000; n++) step();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule